// File: doc/BRIEF.md
# Slot-Based Bandwidth Allocating Bus Arbiter

This arbiter decides which master owns a shared system bus, the one that fronts SDRAM, at every tenure boundary. One master is the CPU. The others, up to sixteen, receive bus time through a rotating table of sixteen slots. Turns alternate between the CPU and the slot under the table pointer, so the CPU holds half of all arbitration opportunities. The other masters share the remaining half in proportion to the slots each one owns.

Software programs each slot through a write port. A slot can be left empty, or it can name a master together with a fraction code. The fraction code lets a master own a slot on only every second, fourth or eighth pass of the rotation. A master that owns several slots gets a larger share, and a master that owns none never wins through the table.

A grant lasts until the bus signals the end of the burst on `done_i`. The next owner is registered on that same clock edge. If no one is requesting, the grant rests on the CPU.

Top module: `slot_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, the grant rests on the CPU (`gnt_o` = bit 0 only, `gnt_idx_o` = 0). The table pointer is at slot 0, the first turn is a table turn, and every slot is empty.
- R2: `gnt_o` is always one-hot, and its set bit is the bit numbered `gnt_idx_o`. Index 0 is the CPU, and indices 1..NUM_MASTERS are the other masters.
- R3: `gnt_o` and `gnt_idx_o` change only on the clock edge at which `done_i` is high. At all other times they hold, whatever happens on the requests.
- R4: Turns alternate between CPU and table at every boundary. On a CPU turn, a requesting CPU wins and the table pointer does not move.
- R5: On a table turn, an eligible, requesting owner of the current slot wins over the CPU. The pointer advances by one slot on every table turn.
- R6: When the side that owns the turn is not requesting, the other side is served. A CPU turn that is handed to a table master consumes the slot and advances the pointer.
- R7: With no eligible requester on either side, the grant rests on the CPU and the pointer still advances.
- R8: A slot is used only when its valid bit is set and its master index lies in 1..NUM_MASTERS. A master named in two slots wins at both. A master named in no slot never wins.
- R9: Each slot has a 3-bit pass counter that increments every time the pointer leaves that slot. Fraction codes 0, 1, 2 and 3 make the owner eligible only when the counter is a multiple of 1, 2, 4 and 8 respectively.
- R10: A table write never changes the current grant. The written slot takes part in the next boundary that reaches it.
- R11: The pointer wraps from slot SLOTS-1 back to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_MASTERS+1 | Request lines; bit 0 is the CPU |
| done_i | input | 1 | Current tenure ends this cycle |
| cfg_we_i | input | 1 | Slot table write strobe |
| cfg_slot_i | input | $clog2(SLOTS) | Slot being written |
| cfg_vld_i | input | 1 | Valid bit for the written slot |
| cfg_mst_i | input | 5 | Master index for the written slot |
| cfg_frac_i | input | 2 | Fraction code: 0 every pass, 1 every 2nd, 2 every 4th, 3 every 8th |
| gnt_o | output | NUM_MASTERS+1 | One-hot grant |
| gnt_idx_o | output | 5 | Index of the granted master |

## Verification
The bench builds the arbiter with NUM_MASTERS = 4 and the default of 16 slots. Four requesters are enough to leave one master without a slot, to give another master two slots, one of them at half rate, and to keep the request patterns readable. With the full 16-slot table kept, the bench walks complete rotations, so it reaches the pointer wrap and the second pass of the half-rate slot, where that slot becomes eligible again.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int MIDX_W = 5;

  typedef enum logic [1:0] {
    FR_ALL    = 2'd0,
    FR_HALF   = 2'd1,
    FR_QUART  = 2'd2,
    FR_EIGHTH = 2'd3
  } frac_e;

  typedef struct packed {
    logic              vld;
    logic [MIDX_W-1:0] mst;
    frac_e             frac;
  } slot_ent_t;
endpackage

// File: rtl/slot_arb_table.sv
module slot_arb_table
  import slot_arb_pkg::*;
#(
  parameter int SLOTS       = 16,
  parameter int NUM_MASTERS = 16,
  localparam int PTR_W      = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_slot_i,
  input  slot_ent_t         wr_ent_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              adv_i,
  output logic [MIDX_W-1:0] owner_o,
  output logic              ok_o
);
  slot_ent_t  ent_q  [SLOTS];
  logic [2:0] pass_q [SLOTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SLOTS; s++) begin
        ent_q[s]  <= '0;
        pass_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (wr_en_i && wr_slot_i == PTR_W'(s)) begin
          ent_q[s]  <= wr_ent_i;
          pass_q[s] <= '0;
        end else if (adv_i && ptr_i == PTR_W'(s)) begin
          pass_q[s] <= pass_q[s] + 3'd1;
        end
      end
    end
  end

  slot_ent_t  cur;
  logic [2:0] cnt;
  logic       elig;
  logic       in_range;

  always_comb begin
    cur = ent_q[ptr_i];
    cnt = pass_q[ptr_i];
    unique case (cur.frac)
      FR_ALL:    elig = 1'b1;
      FR_HALF:   elig = (cnt[0] == 1'b0);
      FR_QUART:  elig = (cnt[1:0] == 2'b00);
      default:   elig = (cnt == 3'b000);
    endcase
    in_range = (cur.mst != '0) && (int'(cur.mst) <= NUM_MASTERS);
  end

  assign owner_o = cur.mst;
  assign ok_o    = cur.vld && in_range && elig;

  // R9: a half-rate slot is never eligible on an odd pass
  assert_half_rate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur.vld && cur.frac == FR_HALF && cnt[0]) |-> !ok_o);
endmodule

// File: rtl/slot_arb_pick.sv
module slot_arb_pick
  import slot_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 16,
  localparam int NREQ       = NUM_MASTERS + 1
) (
  input  logic              cpu_turn_i,
  input  logic [NREQ-1:0]   req_i,
  input  logic              slot_ok_i,
  input  logic [MIDX_W-1:0] owner_i,
  output logic [MIDX_W-1:0] win_o,
  output logic              adv_o
);
  logic owner_req;
  logic tbl_hit;

  always_comb begin
    owner_req = 1'b0;
    for (int m = 1; m < NREQ; m++)
      if (owner_i == MIDX_W'(m)) owner_req = req_i[m];
  end

  assign tbl_hit = slot_ok_i && owner_req;

  always_comb begin
    if (cpu_turn_i) begin
      if (req_i[0]) begin
        win_o = '0;
        adv_o = 1'b0;
      end else begin
        win_o = tbl_hit ? owner_i : '0;  // handed to table, else park
        adv_o = 1'b1;
      end
    end else begin
      win_o = tbl_hit ? owner_i : '0;    // CPU fallback and park share index 0
      adv_o = 1'b1;
    end
  end
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int NUM_MASTERS = 16,
  parameter int SLOTS       = 16,
  localparam int NREQ       = NUM_MASTERS + 1,
  localparam int PTR_W      = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NREQ-1:0]   req_i,
  input  logic              done_i,
  input  logic              cfg_we_i,
  input  logic [PTR_W-1:0]  cfg_slot_i,
  input  logic              cfg_vld_i,
  input  logic [MIDX_W-1:0] cfg_mst_i,
  input  logic [1:0]        cfg_frac_i,
  output logic [NREQ-1:0]   gnt_o,
  output logic [MIDX_W-1:0] gnt_idx_o
);
  logic [PTR_W-1:0]  ptr_q;
  logic              cpu_turn_q;
  logic [NREQ-1:0]   gnt_q;
  logic [MIDX_W-1:0] idx_q;

  logic [MIDX_W-1:0] owner;
  logic              slot_ok;
  logic [MIDX_W-1:0] win;
  logic              adv;
  logic [NREQ-1:0]   gnt_d;
  slot_ent_t         wr_ent;

  assign wr_ent = '{vld: cfg_vld_i, mst: cfg_mst_i, frac: frac_e'(cfg_frac_i)};

  slot_arb_table #(.SLOTS(SLOTS), .NUM_MASTERS(NUM_MASTERS)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_slot_i (cfg_slot_i),
    .wr_ent_i  (wr_ent),
    .ptr_i     (ptr_q),
    .adv_i     (done_i && adv),
    .owner_o   (owner),
    .ok_o      (slot_ok)
  );

  slot_arb_pick #(.NUM_MASTERS(NUM_MASTERS)) u_pick (
    .cpu_turn_i (cpu_turn_q),
    .req_i      (req_i),
    .slot_ok_i  (slot_ok),
    .owner_i    (owner),
    .win_o      (win),
    .adv_o      (adv)
  );

  for (genvar m = 0; m < NREQ; m++) begin : g_dec
    assign gnt_d[m] = (win == MIDX_W'(m));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      cpu_turn_q <= 1'b0;  // parked on CPU, so the first turn is the table's
      gnt_q      <= NREQ'(1);
      idx_q      <= '0;
    end else if (done_i) begin
      cpu_turn_q <= !cpu_turn_q;
      gnt_q      <= gnt_d;
      idx_q      <= win;
      if (adv) ptr_q <= (ptr_q == PTR_W'(SLOTS - 1)) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_idx_o = idx_q;

  assert_onehot_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(gnt_o));
  assert_idx_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o == (NREQ'(1) << gnt_idx_o));
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> ($stable(gnt_o) && $stable(gnt_idx_o)));
  assert_cpu_wins_turn_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && cpu_turn_q && req_i[0]) |=> (gnt_idx_o == '0));
  assert_turn_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (cpu_turn_q != $past(cpu_turn_q)));
  assert_table_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !cpu_turn_q) |=> (ptr_q != $past(ptr_q)));
  assert_park_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && req_i == '0) |=> (gnt_idx_o == '0));
endmodule

// File: tb/sim_slot_arbiter.sv
module sim_slot_arbiter;
  localparam int CLK_P = 10;
  localparam int NM    = 4;
  localparam int NR    = NM + 1;
  localparam int NV    = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NR-1:0] req_i = '0;
  logic          done_i = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [3:0]    cfg_slot_i = '0;
  logic          cfg_vld_i = 1'b0;
  logic [4:0]    cfg_mst_i = '0;
  logic [1:0]    cfg_frac_i = '0;
  logic [NR-1:0] gnt_o;
  logic [4:0]    gnt_idx_o;

  int checks = 0;
  int errors = 0;
  bit fin = 0;

  always #(CLK_P/2) clk = ~clk;

  slot_arbiter #(.NUM_MASTERS(NM)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .done_i(done_i),
    .cfg_we_i(cfg_we_i), .cfg_slot_i(cfg_slot_i), .cfg_vld_i(cfg_vld_i),
    .cfg_mst_i(cfg_mst_i), .cfg_frac_i(cfg_frac_i),
    .gnt_o(gnt_o), .gnt_idx_o(gnt_idx_o)
  );

  // {repeat, req, expected index, requirement}
  localparam logic [16:0] VEC [NV] = '{
    {5'd1,  5'b11111, 3'd1, 4'd5},  // R5 table turn, slot0 -> M1
    {5'd1,  5'b11111, 3'd0, 4'd4},  // R4 CPU turn, CPU wins
    {5'd1,  5'b11111, 3'd2, 4'd5},  // R5 slot1 -> M2
    {5'd1,  5'b00010, 3'd1, 4'd6},  // R6 CPU idle, slot2 half-rate pass 0 -> M1
    {5'd1,  5'b01001, 3'd0, 4'd6},  // R6 empty slot3 hands turn to CPU
    {5'd12, 5'b01000, 3'd0, 4'd8},  // R8 unslotted M3 never wins
    {5'd1,  5'b00010, 3'd1, 4'd11}, // R11 pointer wrapped to slot0
    {5'd1,  5'b00010, 3'd0, 4'd7},  // R7 M2 idle, CPU idle -> park
    {5'd1,  5'b00010, 3'd0, 4'd9},  // R9 half-rate slot skipped on pass 1
    {5'd13, 5'b00000, 3'd0, 4'd7},  // R7 no requests, pointer moves on
    {5'd2,  5'b00000, 3'd0, 4'd7},
    {5'd1,  5'b00010, 3'd1, 4'd9}   // R9 half-rate slot eligible on pass 2
  };

  task automatic chk(input int r, input int exp_idx, input string what);
    checks++;
    if (gnt_idx_o !== 5'(exp_idx) || gnt_o !== (NR'(1) << exp_idx)) begin
      errors++;
      $display("FAIL R%0d %s: idx=%0d gnt=%b expected idx=%0d gnt=%b",
               r, what, gnt_idx_o, gnt_o, exp_idx, NR'(1) << exp_idx);
    end
  endtask

  task automatic tenure(input logic [NR-1:0] r);
    @(negedge clk);
    req_i  = r;
    done_i = 1'b1;
    @(negedge clk);
    done_i = 1'b0;
  endtask

  task automatic wr_slot(input int s, input int m, input int f);
    @(negedge clk);
    cfg_we_i   = 1'b1;
    cfg_slot_i = 4'(s);
    cfg_vld_i  = 1'b1;
    cfg_mst_i  = 5'(m);
    cfg_frac_i = 2'(f);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      errors++;
      checks++;
      $display("FAIL R3 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1, 0, "during reset");
    rst_ni = 1'b1;
    @(negedge clk);
    chk(1, 0, "after reset");

    wr_slot(0, 1, 0);
    wr_slot(1, 2, 0);
    wr_slot(2, 1, 1);          // R8 M1 owns two slots, one half-rate
    chk(10, 0, "writes while parked");

    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VEC[v][16:12]); k++) begin
        tenure(VEC[v][11:7]);
        chk(int'(VEC[v][3:0]), int'(VEC[v][6:4]), $sformatf("vector %0d pass %0d", v, k));
      end
    end

    // R3 grant held with requests dropped and no done
    req_i = '0;
    repeat (5) @(negedge clk);
    chk(3, 1, "hold without done");

    // R10 write mid-tenure leaves grant, applies at next boundary
    wr_slot(3, 4, 0);
    chk(10, 1, "write mid-tenure");
    tenure(5'b10000);
    chk(10, 4, "new slot used");

    // R1 reset clears table
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(1, 0, "reset reasserted");
    rst_ni = 1'b1;
    tenure(5'b11111);
    chk(1, 0, "slots empty after reset");

    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule